// File: doc/BRIEF.md
# Bitwise Logic Unit with Precise Taint Labels

This block applies one bitwise operation (AND, OR or inversion) to two operand vectors. Every data bit arrives with its own one-bit taint label, and the block returns a taint label for every result bit alongside the data result. A result bit is marked tainted only when a tainted input bit could change that result bit. For example, AND with an untainted zero masks a tainted partner, and OR with an untainted one does the same. A plain OR of the input labels would mark both of those cases as tainted, so this block gives fewer false alarms than that scheme.

The second operand may be replaced by an immediate constant. A configuration input decides whether such a constant is treated as tainted or as clean. Both the result and its labels are registered, so they appear one clock after the operands are presented. Bit lanes are computed independently of each other, and the lane count is a parameter.

Top module: `taint_logic_unit`

## Requirements
- R1: With `op` = 2'b00 (AND), the registered result bit is a&b and its label is (a & bt) | (b & at) | (at & bt), where a, b are the operand bits and at, bt their labels.
- R2: With `op` = 2'b01 (OR), the result bit is a|b and its label is (~a & bt) | (~b & at) | (at & bt).
- R3: With `op` = 2'b10 (NOT), the result bit is ~a and its label equals the label of `a`; operand B and its labels have no effect.
- R4: With `op` = 2'b11, the result and its labels are all zero.
- R5: When `imm_en` is high, `imm_val` replaces operand B, and with `cfg_taint_const` low every bit of the replaced operand is labelled clean regardless of `b_tnt`.
- R6: When `imm_en` and `cfg_taint_const` are both high, every bit of the replaced operand is labelled tainted.
- R7: `y` and `y_tnt` change only on the rising edge of `clk`, one cycle after the operands and controls that produce them are sampled.
- R8: A high `rst` on a rising edge clears `y` and `y_tnt` to zero (synchronous, active high).
- R9: Each lane depends only on its own bit position: a result label can be 1 only if that lane's A label or its effective B label is 1.
- R10: When no input label is set and no tainted constant is in use, every result label is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a | input | WIDTH | Operand A data |
| a_tnt | input | WIDTH | Per-bit taint labels of A |
| b | input | WIDTH | Operand B data |
| b_tnt | input | WIDTH | Per-bit taint labels of B |
| op | input | 2 | Operation: 00 AND, 01 OR, 10 NOT A, 11 zero |
| imm_en | input | 1 | Replace B by the immediate constant |
| imm_val | input | WIDTH | Immediate constant value |
| cfg_taint_const | input | 1 | Label constants as tainted when high |
| y | output | WIDTH | Registered result |
| y_tnt | output | WIDTH | Registered per-bit result labels |

## Verification
The hardest cases to reach are the masking cases. In these, a tainted input bit must produce a clean result bit because the partner bit is a clean controlling value: a clean 0 for AND, a clean 1 for OR. Random operands with random labels seldom line up that way across a full lane. So the stimulus broadcasts every one of the sixteen single-lane combinations of data and label to all lanes, for each operation. It then repeats the masking cases with the immediate constant as the clean or tainted partner.

// File: rtl/taint_pkg.sv
package taint_pkg;
   typedef enum logic [1:0] {
      OP_AND  = 2'b00,
      OP_OR   = 2'b01,
      OP_NOTA = 2'b10,
      OP_ZERO = 2'b11
   } tl_op_e;

   typedef struct packed {
      logic val;
      logic tnt;
   } tl_bit_t;
endpackage

// File: rtl/tl_operand_sel.sv
module tl_operand_sel #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] b,
   input  logic [WIDTH-1:0] b_tnt,
   input  logic             imm_en,
   input  logic [WIDTH-1:0] imm_val,
   input  logic             cfg_taint_const,
   output logic [WIDTH-1:0] b_eff,
   output logic [WIDTH-1:0] bt_eff
);
   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

   always_comb begin
      if (imm_en) begin
         b_eff  = imm_val;
         bt_eff = cfg_taint_const ? ALL_ONES : '0;
      end else begin
         b_eff  = b;
         bt_eff = b_tnt;
      end
   end

   always_comb begin
      if (imm_en && !cfg_taint_const)
         p_clean_const_r5: assert (bt_eff == '0);
      if (imm_en && cfg_taint_const)
         p_dirty_const_r6: assert (bt_eff == ALL_ONES);
   end
endmodule

// File: rtl/tl_lane.sv
module tl_lane
   import taint_pkg::*;
(
   input  tl_op_e  op,
   input  tl_bit_t src_a,
   input  tl_bit_t src_b,
   output tl_bit_t res
);
   logic and_t, or_t;

   always_comb begin
      and_t = (src_a.val & src_b.tnt) | (src_b.val & src_a.tnt) | (src_a.tnt & src_b.tnt);
      or_t  = (~src_a.val & src_b.tnt) | (~src_b.val & src_a.tnt) | (src_a.tnt & src_b.tnt);
      unique case (op)
         OP_AND:  res = '{val: src_a.val & src_b.val, tnt: and_t};
         OP_OR:   res = '{val: src_a.val | src_b.val, tnt: or_t};
         OP_NOTA: res = '{val: ~src_a.val,            tnt: src_a.tnt};
         default: res = '{val: 1'b0,                  tnt: 1'b0};
      endcase
   end

   always_comb begin
      p_label_source_r9: assert (!(res.tnt && !src_a.tnt && !src_b.tnt));
   end
endmodule

// File: rtl/tl_out_reg.sv
module tl_out_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_val,
   input  logic [WIDTH-1:0] d_tnt,
   output logic [WIDTH-1:0] q_val,
   output logic [WIDTH-1:0] q_tnt
);
   always_ff @(posedge clk) begin
      if (rst) begin
         q_val <= '0;
         q_tnt <= '0;
      end else begin
         q_val <= d_val;
         q_tnt <= d_tnt;
      end
   end

   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> (q_val == '0 && q_tnt == '0));
endmodule

// File: rtl/taint_logic_unit.sv
module taint_logic_unit
   import taint_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] a_tnt,
   input  logic [WIDTH-1:0] b,
   input  logic [WIDTH-1:0] b_tnt,
   input  logic [1:0]       op,
   input  logic             imm_en,
   input  logic [WIDTH-1:0] imm_val,
   input  logic             cfg_taint_const,
   output logic [WIDTH-1:0] y,
   output logic [WIDTH-1:0] y_tnt
);
   if (WIDTH < 1) begin : g_bad_width
      $error("taint_logic_unit: WIDTH must be at least 1");
   end

   tl_op_e           op_e;
   logic [WIDTH-1:0] b_eff, bt_eff;
   logic [WIDTH-1:0] r_val, r_tnt;

   assign op_e = tl_op_e'(op);

   tl_operand_sel #(.WIDTH(WIDTH)) u_sel (
      .b              (b),
      .b_tnt          (b_tnt),
      .imm_en         (imm_en),
      .imm_val        (imm_val),
      .cfg_taint_const(cfg_taint_const),
      .b_eff          (b_eff),
      .bt_eff         (bt_eff)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      tl_bit_t la, lb, lr;
      assign la = '{val: a[i],     tnt: a_tnt[i]};
      assign lb = '{val: b_eff[i], tnt: bt_eff[i]};
      tl_lane u_lane (
         .op   (op_e),
         .src_a(la),
         .src_b(lb),
         .res  (lr)
      );
      assign r_val[i] = lr.val;
      assign r_tnt[i] = lr.tnt;
   end

   tl_out_reg #(.WIDTH(WIDTH)) u_oreg (
      .clk  (clk),
      .rst  (rst),
      .d_val(r_val),
      .d_tnt(r_tnt),
      .q_val(y),
      .q_tnt(y_tnt)
   );

   p_and_value_r1: assert property (@(posedge clk) disable iff (rst)
      (op == 2'b00 && !imm_en) |=> (y == ($past(a) & $past(b))));
   p_or_value_r2: assert property (@(posedge clk) disable iff (rst)
      (op == 2'b01 && !imm_en) |=> (y == ($past(a) | $past(b))));
   p_not_label_r3: assert property (@(posedge clk) disable iff (rst)
      (op == 2'b10) |=> (y == ~$past(a) && y_tnt == $past(a_tnt)));
   p_zero_op_r4: assert property (@(posedge clk) disable iff (rst)
      (op == 2'b11) |=> (y == '0 && y_tnt == '0));
   p_clean_in_r10: assert property (@(posedge clk) disable iff (rst)
      (a_tnt == '0 && (imm_en ? !cfg_taint_const : b_tnt == '0)) |=> (y_tnt == '0));
   p_held_r7: assert property (@(posedge clk) disable iff (rst)
      $stable(r_val) && $stable(r_tnt) |=> (y == $past(r_val) && y_tnt == $past(r_tnt)));
endmodule

// File: tb/sim_taint_logic_unit.sv
module sim_taint_logic_unit;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;

   logic         clk = 0;
   logic         rst;
   logic [W-1:0] a, a_tnt, b, b_tnt, imm_val;
   logic [1:0]   op;
   logic         imm_en, cfg_taint_const;
   logic [W-1:0] y, y_tnt;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   taint_logic_unit #(.WIDTH(W)) u0 (
      .clk(clk), .rst(rst), .a(a), .a_tnt(a_tnt), .b(b), .b_tnt(b_tnt),
      .op(op), .imm_en(imm_en), .imm_val(imm_val),
      .cfg_taint_const(cfg_taint_const), .y(y), .y_tnt(y_tnt)
   );

   function automatic void ref_model(input logic [1:0] o, input logic [W-1:0] ra, rat,
                                     rb, rbt, output logic [W-1:0] ey, eyt);
      case (o)
         2'b00: begin ey = ra & rb; eyt = (ra & rbt) | (rb & rat) | (rat & rbt); end
         2'b01: begin ey = ra | rb; eyt = (~ra & rbt) | (~rb & rat) | (rat & rbt); end
         2'b10: begin ey = ~ra;     eyt = rat; end
         default: begin ey = '0;    eyt = '0; end
      endcase
   endfunction

   task automatic check(input string tag, input logic [W-1:0] ey, eyt);
      n_vec++;
      if (y !== ey || y_tnt !== eyt) begin
         n_bad++;
         $display("FAIL %s: y=%h y_tnt=%h expected y=%h y_tnt=%h", tag, y, y_tnt, ey, eyt);
      end
   endtask

   // drive at a falling edge, result registered at the next rising edge, sample at the falling edge after
   task automatic apply(input string tag, input logic [1:0] o, input logic [W-1:0] va, vat,
                        vb, vbt, input logic ie, input logic [W-1:0] iv, input logic cfg);
      logic [W-1:0] ey, eyt, bb, bbt;
      @(negedge clk);
      op = o; a = va; a_tnt = vat; b = vb; b_tnt = vbt;
      imm_en = ie; imm_val = iv; cfg_taint_const = cfg;
      bb  = ie ? iv : vb;
      bbt = ie ? (cfg ? '1 : '0) : vbt;
      ref_model(o, va, vat, bb, bbt, ey, eyt);
      @(negedge clk);
      check(tag, ey, eyt);
   endtask

   task automatic t_reset();
      rst = 1; op = 0; a = '1; a_tnt = '1; b = '1; b_tnt = '1;
      imm_en = 0; imm_val = 0; cfg_taint_const = 0;
      repeat (2) @(negedge clk);
      check("R8", '0, '0);
      rst = 0;
   endtask

   task automatic t_exhaustive();
      for (int o = 0; o < 4; o++)
         for (int c = 0; c < 16; c++)
            apply(o == 0 ? "R1" : o == 1 ? "R2" : o == 2 ? "R3" : "R4", 2'(o),
                  {W{c[3]}}, {W{c[2]}}, {W{c[1]}}, {W{c[0]}}, 1'b0, '0, 1'b0);
   endtask

   task automatic t_random();
      for (int k = 0; k < 200; k++) begin
         logic [1:0] o = 2'($urandom);
         apply("R9", o, W'($urandom), W'($urandom), W'($urandom), W'($urandom),
               1'b0, '0, 1'b0);
      end
   endtask

   task automatic t_masking();
      // tainted A lanes masked by clean 0 (AND) or clean 1 (OR): no label
      apply("R1", 2'b00, '1, '1, '0, '0, 1'b0, '0, 1'b0);
      apply("R2", 2'b01, '0, '1, '1, '0, 1'b0, '0, 1'b0);
      // NOT ignores B entirely
      apply("R3", 2'b10, 8'h5A, 8'h0F, 8'hFF, 8'hFF, 1'b0, '0, 1'b0);
   endtask

   task automatic t_immediate();
      apply("R5", 2'b00, 8'hF0, 8'h00, 8'hFF, 8'hFF, 1'b1, 8'h3C, 1'b0);
      apply("R5", 2'b01, 8'h0F, 8'hFF, 8'h00, 8'hFF, 1'b1, 8'hFF, 1'b0);
      apply("R6", 2'b00, 8'hF0, 8'h00, 8'h00, 8'h00, 1'b1, 8'h3C, 1'b1);
      apply("R6", 2'b01, 8'hA5, 8'h00, 8'h00, 8'h00, 1'b1, 8'h00, 1'b1);
      apply("R10", 2'b01, 8'hA5, 8'h00, 8'h33, 8'hFF, 1'b1, 8'h0F, 1'b0);
   endtask

   task automatic t_lanes();
      apply("R9", 2'b00, '1, 8'h08, '1, '0, 1'b0, '0, 1'b0);
      apply("R10", 2'b00, 8'hC3, '0, 8'h6E, '0, 1'b0, '0, 1'b0);
   endtask

   task automatic t_timing();
      // R7: output must still show the old vector until the next rising edge
      apply("R7", 2'b00, '1, '0, '1, '0, 1'b0, '0, 1'b0);
      @(negedge clk);
      op = 2'b11;
      #1 check("R7", '1, '0);
      @(negedge clk);
      check("R7", '0, '0);
      // R8 mid-run reset
      apply("R8", 2'b10, 8'h00, 8'hFF, '0, '0, 1'b0, '0, 1'b0);
      @(negedge clk); rst = 1;
      @(negedge clk); check("R8", '0, '0); rst = 0;
   endtask

   initial begin
      t_reset();
      t_exhaustive();
      t_masking();
      t_immediate();
      t_lanes();
      t_random();
      t_timing();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule